// File: doc/BRIEF.md
# Lookup-Table Histogram Track Finder

This block searches a sparse region of a four-layer silicon strip tracker for the straight track best supported by the hits. Each hit is a layer number and a strip coordinate. A table written by the host turns the hit into the set of road patterns it is compatible with. A pattern is a slope index and an intercept index. For every pattern, the block keeps a per-layer hit mask. Once the event's hits are in, it scans the masks and reports the pattern that has the most distinct layers.

The search grid is 64 slopes by 32 intercepts, which is too large for one pass. One pass covers 64 slopes by 16 intercepts, and the pass number selects the half of the table in use. A pass can merge its winner with the winner kept from the previous pass. This lets an event be processed in two passes and still yield the best pattern over the whole grid. A track is declared only when at least three of the four layers line up.

The host uses the block in this order:
1. Write the table.
2. Pulse `ev_start` with a pass number and a keep flag.
3. Stream hits one per clock while `hit_ready` is high.
4. Pulse `ev_end`.
5. Wait for the single-cycle `res_valid`.

Top module: `lut_track_finder`

## Requirements
- R1: After reset, `res_valid`, `hit_ready`, `res_found`, `res_score`, `res_slope` and `res_icpt` are all 0.
- R2: A cycle with `lut_we` high stores `lut_wdata` at `lut_addr`. The address is laid out from MSB to LSB as {pass (1 bit), layer (2 bits), coordinate (3 bits), slope (6 bits)}. Bit i of the stored word is local intercept i of that slope row.
- R3: An accepted hit on layer L with coordinate C during pass P sets bit L of every histogram cell (s, i) for which bit i of the table word at {P, L, C, s} is 1.
- R4: The score of a cell is the number of distinct layers set in its mask. Repeated hits from one layer on a cell add nothing.
- R5: The reported pattern has the highest score. Ties go to the lowest slope, then to the lowest global intercept.
- R6: `res_found` is 1 exactly when the reported score is 3 or more.
- R7: `ev_start` clears every histogram cell, so hits from an earlier event never count.
- R8: The global intercept is pass*16 + local intercept. With `ev_keep`=1 the pass result is merged with the kept result under the R5 ordering. Outside `ev_start` the result outputs change only in the cycle that `res_valid` rises.
- R9: With `ev_keep`=0 the kept result is discarded at `ev_start`. An empty event then reports score 0, slope 0 and intercept 0.
- R10: After `ev_end`, `hit_ready` is 0 and offered hits are ignored until the next `ev_start`. The result appears as a one-cycle `res_valid` pulse within 70 cycles.
- R11: In the cycle after `ev_start`, `hit_ready` is 1. With the default parallel sweep, one hit is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 12 | Table address {pass, layer, coordinate, slope} |
| lut_wdata | input | 16 | Intercept mask for one slope row |
| ev_start | input | 1 | Start a pass; clears the histogram |
| ev_pass | input | 1 | Pass index for the pass being started |
| ev_keep | input | 1 | Merge with the kept result (1) or drop it (0) |
| hit_valid | input | 1 | Hit offered |
| hit_layer | input | 2 | Layer of the hit |
| hit_coord | input | 3 | Strip coordinate of the hit |
| hit_ready | output | 1 | Hit accepted in this cycle if offered |
| ev_end | input | 1 | Last hit sent; begin the scan |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | Score reaches three layers |
| res_slope | output | 6 | Slope index of the best pattern |
| res_icpt | output | 5 | Global intercept index of the best pattern |
| res_score | output | 3 | Number of layers on the best pattern |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:
- **Repeated hits on one layer:** a design that counted hits instead of layers would report an inflated score and could claim a track.
- **Equal-score patterns:** the bench places them on the same slope row and on different rows. A wrong tie-break would name the later one.
- **Consecutive events:** the second event's hits complete a track only if residue from the first survives. A design that missed the clear would report four layers.
- **Two-pass merging:**
  - a pass-1 winner must come out with intercept 16 or higher;
  - a weaker later pass must not displace a kept winner;
  - a pass started without keep must forget the previous winner.
- **Hits offered after `ev_end`:** these would turn a three-layer track into a four-layer one if they were wrongly accepted.

// File: rtl/lut_track_finder.sv
module lut_track_finder #(
  parameter int N_SLOPE    = 64,
  parameter int N_ICPT     = 16,
  parameter int N_PASS     = 2,
  parameter int N_LAYER    = 4,
  parameter int COORD_W    = 3,
  parameter int GROUP      = 64,
  parameter int MIN_LAYERS = 3,
  localparam int SLOPE_W = $clog2(N_SLOPE),
  localparam int ICPT_W  = $clog2(N_ICPT),
  localparam int PASS_W  = $clog2(N_PASS),
  localparam int LAYER_W = $clog2(N_LAYER),
  localparam int GICPT_W = PASS_W + ICPT_W,
  localparam int SCORE_W = $clog2(N_LAYER + 1),
  localparam int LUT_AW  = PASS_W + LAYER_W + COORD_W + SLOPE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lut_we,
  input  logic [LUT_AW-1:0]  lut_addr,
  input  logic [N_ICPT-1:0]  lut_wdata,
  input  logic               ev_start,
  input  logic [PASS_W-1:0]  ev_pass,
  input  logic               ev_keep,
  input  logic               hit_valid,
  input  logic [LAYER_W-1:0] hit_layer,
  input  logic [COORD_W-1:0] hit_coord,
  output logic               hit_ready,
  input  logic               ev_end,
  output logic               res_valid,
  output logic               res_found,
  output logic [SLOPE_W-1:0] res_slope,
  output logic [GICPT_W-1:0] res_icpt,
  output logic [SCORE_W-1:0] res_score
);
  localparam int N_GRP = N_SLOPE / GROUP;
  localparam int GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DRAIN, S_SCAN} st_t;
  st_t st;

  logic [N_ICPT-1:0]  lut  [2**LUT_AW];
  logic [N_LAYER-1:0] hist [N_SLOPE][N_ICPT];
  logic [N_ICPT-1:0]  gmask [GROUP];

  logic [PASS_W-1:0]  cur_pass;
  logic               h_pend;
  logic [LAYER_W-1:0] h_layer;
  logic [COORD_W-1:0] h_coord;
  logic [GRP_W-1:0]   grp;
  logic [SLOPE_W-1:0] row;

  logic [SCORE_W-1:0] pb_score, rb_score, pf_score, kb_score;
  logic [ICPT_W-1:0]  pb_icpt, rb_icpt, pf_icpt;
  logic [SLOPE_W-1:0] pb_slope, pf_slope, kb_slope;
  logic [GICPT_W-1:0] pf_gicpt, kb_icpt;
  logic               rb_better, merge_better, grp_last, hit_take;

  function automatic logic [SCORE_W-1:0] popc(input logic [N_LAYER-1:0] v);
    popc = '0;
    for (int k = 0; k < N_LAYER; k++) popc += SCORE_W'(v[k]);
  endfunction

  assign grp_last  = (grp == GRP_W'(N_GRP - 1));
  assign hit_ready = (st == S_ACC) && (!h_pend || grp_last);
  assign hit_take  = hit_valid && hit_ready;

  always_ff @(posedge clk)
    if (lut_we) lut[lut_addr] <= lut_wdata;

  always_comb
    for (int g = 0; g < GROUP; g++)
      gmask[g] = lut[{cur_pass, h_layer, h_coord, SLOPE_W'(int'(grp) * GROUP + g)}];

  always_ff @(posedge clk) begin
    if (!rst_n || ev_start) begin
      for (int s = 0; s < N_SLOPE; s++)
        for (int i = 0; i < N_ICPT; i++) hist[s][i] <= '0;
    end else if (h_pend) begin
      for (int g = 0; g < GROUP; g++)
        for (int i = 0; i < N_ICPT; i++)
          if (gmask[g][i]) hist[SLOPE_W'(int'(grp) * GROUP + g)][i][h_layer] <= 1'b1;
    end
  end

  always_comb begin
    rb_score = '0;
    rb_icpt  = '0;
    for (int i = 0; i < N_ICPT; i++)
      if (popc(hist[row][i]) > rb_score) begin
        rb_score = popc(hist[row][i]);
        rb_icpt  = ICPT_W'(i);
      end
  end

  assign rb_better = rb_score > pb_score;
  assign pf_score  = rb_better ? rb_score : pb_score;
  assign pf_icpt   = rb_better ? rb_icpt  : pb_icpt;
  assign pf_slope  = rb_better ? row      : pb_slope;
  assign pf_gicpt  = {cur_pass, pf_icpt};
  assign merge_better = (pf_score > kb_score) ||
                        ((pf_score == kb_score) &&
                         ((pf_slope < kb_slope) ||
                          ((pf_slope == kb_slope) && (pf_gicpt < kb_icpt))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur_pass <= '0;
      h_pend <= 1'b0;
      h_layer <= '0;
      h_coord <= '0;
      grp <= '0;
      row <= '0;
      pb_score <= '0; pb_icpt <= '0; pb_slope <= '0;
      kb_score <= '0; kb_icpt <= '0; kb_slope <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (ev_start) begin
        st <= S_ACC;
        cur_pass <= ev_pass;
        h_pend <= 1'b0;
        grp <= '0;
        if (!ev_keep) begin
          kb_score <= '0; kb_icpt <= '0; kb_slope <= '0;
        end
      end else begin
        if (h_pend) begin
          if (grp_last) begin
            h_pend <= 1'b0;
            grp <= '0;
          end else grp <= grp + 1'b1;
        end
        if (hit_take) begin
          h_pend <= 1'b1;
          h_layer <= hit_layer;
          h_coord <= hit_coord;
          grp <= '0;
        end
        case (st)
          S_ACC: if (ev_end) st <= S_DRAIN;
          S_DRAIN:
            if (!h_pend || grp_last) begin
              st <= S_SCAN;
              row <= '0;
              pb_score <= '0; pb_icpt <= '0; pb_slope <= '0;
            end
          S_SCAN: begin
            pb_score <= pf_score;
            pb_icpt  <= pf_icpt;
            pb_slope <= pf_slope;
            row <= row + 1'b1;
            if (row == SLOPE_W'(N_SLOPE - 1)) begin
              st <= S_IDLE;
              res_valid <= 1'b1;
              if (merge_better) begin
                kb_score <= pf_score;
                kb_slope <= pf_slope;
                kb_icpt  <= pf_gicpt;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign res_found = kb_score >= SCORE_W'(MIN_LAYERS);
  assign res_slope = kb_slope;
  assign res_icpt  = kb_icpt;
  assign res_score = kb_score;
endmodule

// File: rtl/lut_track_finder_chk.sv
module lut_track_finder_chk #(
  parameter int SLOPE_W = 6,
  parameter int GICPT_W = 5,
  parameter int SCORE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_start,
  input logic               ev_end,
  input logic               hit_ready,
  input logic               res_valid,
  input logic [SLOPE_W-1:0] res_slope,
  input logic [GICPT_W-1:0] res_icpt,
  input logic [SCORE_W-1:0] res_score
);
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10
  AST_RES_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !hit_ready); // R10
  AST_END_BLOCKS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end && hit_ready && !ev_start) |=> !hit_ready); // R10
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> hit_ready); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !$past(ev_start)) |->
      ($stable(res_score) && $stable(res_slope) && $stable(res_icpt))); // R8
endmodule

bind lut_track_finder lut_track_finder_chk #(
  .SLOPE_W(SLOPE_W), .GICPT_W(GICPT_W), .SCORE_W(SCORE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_end(ev_end),
  .hit_ready(hit_ready), .res_valid(res_valid), .res_slope(res_slope),
  .res_icpt(res_icpt), .res_score(res_score)
);

// File: tb/lut_track_finder_tb_top.sv
`timescale 1ns/1ps
module lut_track_finder_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        lut_we = 0;
  logic [11:0] lut_addr = '0;
  logic [15:0] lut_wdata = '0;
  logic        ev_start = 0, ev_keep = 0, ev_end = 0;
  logic [0:0]  ev_pass = '0;
  logic        hit_valid = 0;
  logic [1:0]  hit_layer = '0;
  logic [2:0]  hit_coord = '0;
  logic        hit_ready, res_valid, res_found;
  logic [5:0]  res_slope;
  logic [4:0]  res_icpt;
  logic [2:0]  res_score;

  lut_track_finder dut_i (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] blut [4096];
  logic [3:0]  mh [64][16];
  int kb_s, kb_sl, kb_ic;
  int hl [64];
  int hc [64];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int addr_of(int p, int l, int c, int s);
    return (p << 11) | (l << 9) | (c << 6) | s;
  endfunction

  function automatic int popc(logic [3:0] v);
    return v[0] + v[1] + v[2] + v[3];
  endfunction

  task automatic wr(int a, logic [15:0] d);
    lut_we = 1; lut_addr = 12'(a); lut_wdata = d; blut[a] = d;
    @(negedge clk);
    lut_we = 0;
  endtask

  task automatic clear_lut();
    for (int a = 0; a < 4096; a++) begin
      lut_we = 1; lut_addr = 12'(a); lut_wdata = '0; blut[a] = '0;
      @(negedge clk);
    end
    lut_we = 0;
  endtask

  task automatic run_event(int p, bit keep, int n, bit late, string tag);
    int w;
    ev_start = 1; ev_pass = 1'(p); ev_keep = keep;
    @(negedge clk);
    ev_start = 0;
    for (int s = 0; s < 64; s++) for (int i = 0; i < 16; i++) mh[s][i] = '0;
    if (!keep) begin kb_s = 0; kb_sl = 0; kb_ic = 0; end
    chk({tag, " R11 ready after start"}, hit_ready, 1);
    for (int k = 0; k < n; k++) begin
      hit_valid = 1; hit_layer = 2'(hl[k]); hit_coord = 3'(hc[k]);
      for (int s = 0; s < 64; s++)
        for (int i = 0; i < 16; i++)
          if (blut[addr_of(p, hl[k], hc[k], s)][i]) mh[s][i][hl[k]] = 1'b1;
      @(negedge clk);
    end
    hit_valid = 0; ev_end = 1;
    @(negedge clk);
    ev_end = 0;
    if (late) begin
      hit_valid = 1; hit_layer = 2'd3; hit_coord = 3'(hc[0]);
      chk({tag, " R10 not ready after end"}, hit_ready, 0);
      repeat (3) @(negedge clk);
      hit_valid = 0;
    end
    w = 0;
    while (!res_valid && w < 200) begin @(negedge clk); w++; end
    chk({tag, " R10 result within bound"}, (w < 70) ? 1 : 0, 1);
    for (int s = 0; s < 64; s++)
      for (int i = 0; i < 16; i++) begin
        int sc, g;
        sc = popc(mh[s][i]);
        g = p * 16 + i;
        if (sc > kb_s || (sc == kb_s && (s < kb_sl || (s == kb_sl && g < kb_ic)))) begin
          kb_s = sc; kb_sl = s; kb_ic = g;
        end
      end
    chk({tag, " R4 score"}, res_score, kb_s);
    chk({tag, " R5 slope"}, res_slope, kb_sl);
    chk({tag, " R8 intercept"}, res_icpt, kb_ic);
    chk({tag, " R6 found"}, res_found, (kb_s >= 3) ? 1 : 0);
    @(negedge clk);
    chk({tag, " R10 pulse"}, res_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    kb_s = 0; kb_sl = 0; kb_ic = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 hit_ready", hit_ready, 0);
    chk("R1 score", res_score, 0);
    chk("R1 found", res_found, 0);
    chk("R1 slope", res_slope, 0);
    chk("R1 icpt", res_icpt, 0);

    clear_lut();
    run_event(0, 0, 0, 0, "empty R9");
    chk("R9 empty score", res_score, 0);

    for (int l = 0; l < 4; l++) wr(addr_of(0, l, 1, 5), 16'h0080);
    for (int l = 0; l < 4; l++) begin hl[l] = l; hc[l] = 1; end
    run_event(0, 0, 4, 0, "four layers R3 R2");
    chk("R3 explicit slope", res_slope, 5);
    chk("R3 explicit icpt", res_icpt, 7);

    for (int l = 0; l < 3; l++) begin
      wr(addr_of(0, l, 2, 3), 16'h1010);
      wr(addr_of(0, l, 2, 9), 16'h0004);
      hl[l] = l; hc[l] = 2;
    end
    run_event(0, 0, 3, 0, "tie R5");
    chk("R5 tie slope", res_slope, 3);
    chk("R5 tie icpt", res_icpt, 4);

    hl[0] = 0; hl[1] = 0; hl[2] = 0; hl[3] = 1;
    for (int k = 0; k < 4; k++) hc[k] = 1;
    run_event(0, 0, 4, 0, "duplicate R4");
    chk("R4 duplicate score", res_score, 2);

    hl[0] = 2; hl[1] = 3; hc[0] = 1; hc[1] = 1;
    run_event(0, 0, 2, 0, "clear R7");
    chk("R7 no residue", res_score, 2);

    for (int l = 0; l < 3; l++) begin hl[l] = l; hc[l] = 1; end
    run_event(0, 0, 3, 1, "late hit R10");
    chk("R10 late hit ignored", res_score, 3);

    for (int l = 0; l < 4; l++) wr(addr_of(1, l, 3, 2), 16'h0020);
    for (int l = 0; l < 3; l++) begin hl[l] = l; hc[l] = 1; end
    run_event(0, 0, 3, 0, "pass0 R8");
    for (int l = 0; l < 4; l++) begin hl[l] = l; hc[l] = 3; end
    run_event(1, 1, 4, 0, "pass1 keep R8");
    chk("R8 global icpt", res_icpt, 21);
    for (int l = 0; l < 3; l++) begin hl[l] = l; hc[l] = 1; end
    run_event(0, 1, 3, 0, "weaker keep R8");
    chk("R8 kept winner", res_icpt, 21);
    hl[0] = 0; hl[1] = 1; hc[0] = 3; hc[1] = 3;
    run_event(1, 0, 2, 0, "drop R9");
    chk("R9 dropped score", res_score, 2);

    for (int a = 0; a < 4096; a++) begin
      lut_we = 1; lut_addr = 12'(a);
      lut_wdata = 16'($urandom & $urandom & $urandom);
      blut[a] = lut_wdata;
      @(negedge clk);
    end
    lut_we = 0;
    for (int e = 0; e < 8; e++) begin
      int n;
      n = $urandom_range(0, 40);
      for (int k = 0; k < n; k++) begin
        hl[k] = $urandom_range(0, 3);
        hc[k] = $urandom_range(0, 7);
      end
      run_event($urandom_range(0, 1), 1'($urandom_range(0, 1)), n, 1'($urandom_range(0, 1)), "random R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule